// File: doc/BRIEF.md
# Programmable SPI shift sequencer

This block runs one single-lane SPI transaction from a small byte-wide register file. Software loads up to six transmit bytes, a transaction length in bits, and then sets the go bit in the command register. The engine pulls chip select low and shifts the transmit bytes out MSB first, starting with the highest-numbered slot. If the length runs past the loaded bytes, it keeps clocking with MOSI held low. Every bit on MISO is shifted into a bank of ten receive byte slots. When the last bit is done, chip select is released and the go bit clears itself, so software can poll it to detect completion.

The serial clock is the system clock divided by an even parameter `DIV`, in SPI mode 0. The length register counts bits rather than bytes, so partial trailing bytes are possible. A length of zero or above 56 is rejected without any bus activity.

Register map (5-bit address, byte data): 0x00 command (bit 2 = go/busy), 0x01 length in bits, 0x02–0x07 transmit slots 0–5, 0x08–0x11 receive slots 0–9. Other addresses read as zero.

Top module: `spi_prog_shifter`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, and the command and length registers read 0. Whenever cs_n is 1, mosi is 0.
- R2: A write to address 0x00 with bit 2 set, while idle and with a length of 1 to 56, drives cs_n low in the next cycle. From then until the transfer ends, address 0x00 reads back with bit 2 set.
- R3: Each bit period is `DIV/2` system cycles with sclk low, then `DIV/2` cycles with sclk high. Exactly as many sclk pulses as the length are produced, and sclk is high only while cs_n is low.
- R4: Bit b of the transfer (counting from 0) drives mosi from transmit slot `5 - b/8`, bit `7 - b%8`. Slot 5 goes out first, MSB first, and a partial last byte sends only its upper bits. mosi holds its value for the whole bit period.
- R5: Bits with index 48 or above drive mosi low.
- R6: miso is sampled on each sclk rising edge. The receive bank is cleared at start, and received bits enter it as one shift register. Receive slot 0 holds the last 8 bits, with the final bit in its LSB. Slot k holds the 8 bits received before those of slot k-1. Slots beyond the received bits read 0.
- R7: After the final sclk falling edge, sclk stays low for `DIV/2` more cycles. Then cs_n rises and bit 2 of address 0x00 reads 0.
- R8: A go write with a length of 0 or above 56 causes no cs_n, sclk or mosi activity, and address 0x00 reads 0 in the next cycle.
- R9: While a transfer runs, writes to the command, length and transmit registers are ignored. Their readback values and the bits on mosi are unchanged.
- R10: cs_n stays low without a break from the start cycle to the end defined in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong bit counter or half-period counter shows up on sclk or mosi within one half period, because the bench predicts every pin on every cycle. A wrong end condition shows up as cs_n staying low, or rising, one or more cycles away from the predicted release cycle. A fault in the receive shift path stays hidden until the receive slots are read after the transfer. Each transfer therefore ends with all ten slots compared against the bits the bench drove on miso. Frozen-register faults are caught by writing during a transfer, then reading back and watching mosi.

// File: rtl/spq_pkg.sv
package spq_pkg;
  localparam int SPQ_TX_SLOTS = 6;
  localparam int SPQ_RX_SLOTS = 10;
  localparam int SPQ_MAX_BITS = 56;
  localparam int SPQ_GO_BIT   = 2;

  localparam int SPQ_A_CMD = 0;
  localparam int SPQ_A_LEN = 1;
  localparam int SPQ_A_TX0 = 2;
  localparam int SPQ_A_RX0 = 8;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TAIL  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spq_half_timer.sv
module spq_half_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_end_o
);
  localparam int CW = $clog2(HALF) + 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign half_end_o = run_i && (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || half_end_o) cnt_d = '0;
    else                      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HALF)); // R3
endmodule

// File: rtl/spq_regs.sv
module spq_regs
  import spq_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter int TX_SLOTS = SPQ_TX_SLOTS,
  parameter int RX_SLOTS = SPQ_RX_SLOTS,
  parameter int MAX_BITS = SPQ_MAX_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic                   busy_i,
  input  logic [RX_SLOTS*8-1:0]  rx_i,
  output logic [DW-1:0]          rdata_o,
  output logic [TX_SLOTS*8-1:0]  tx_o,
  output logic [DW-1:0]          len_o,
  output logic                   start_o
);
  logic [DW-1:0] len_q, len_d;
  logic [7:0]    tx_q [TX_SLOTS];
  logic [TX_SLOTS-1:0] tx_we;
  logic          len_ok;
  logic          wr_free;

  assign wr_free = wr_i && !busy_i;
  assign len_ok  = (len_q != '0) && (len_q <= DW'(MAX_BITS));
  assign start_o = wr_free && (addr_i == AW'(SPQ_A_CMD)) &&
                   wdata_i[SPQ_GO_BIT] && len_ok;
  assign len_o   = len_q;

  always_comb begin
    len_d = len_q;
    if (wr_free && (addr_i == AW'(SPQ_A_LEN))) len_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  for (genvar g = 0; g < TX_SLOTS; g++) begin : g_tx
    assign tx_we[g] = wr_free && (addr_i == AW'(SPQ_A_TX0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_q[g] <= '0;
      else if (tx_we[g]) tx_q[g] <= wdata_i[7:0];
    end
    assign tx_o[g*8 +: 8] = tx_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(SPQ_A_CMD)) rdata_o[SPQ_GO_BIT] = busy_i;
    if (addr_i == AW'(SPQ_A_LEN)) rdata_o = len_q;
    for (int k = 0; k < TX_SLOTS; k++)
      if (addr_i == AW'(SPQ_A_TX0 + k)) rdata_o = DW'(tx_q[k]);
    for (int k = 0; k < RX_SLOTS; k++)
      if (addr_i == AW'(SPQ_A_RX0 + k)) rdata_o = DW'(rx_i[k*8 +: 8]);
  end

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(len_q)); // R9
  AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(tx_o)); // R9
endmodule

// File: rtl/spq_engine.sv
module spq_engine
  import spq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int TX_SLOTS = SPQ_TX_SLOTS,
  parameter int RX_SLOTS = SPQ_RX_SLOTS,
  parameter int MAX_BITS = SPQ_MAX_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [DW-1:0]         len_i,
  input  logic [TX_SLOTS*8-1:0] tx_i,
  input  logic                  miso_i,
  input  logic                  half_end_i,
  output logic                  busy_o,
  output logic                  sclk_o,
  output logic                  cs_n_o,
  output logic                  mosi_o,
  output logic [RX_SLOTS*8-1:0] rx_o
);
  localparam int BW  = $clog2(MAX_BITS);
  localparam int BYW = BW - 3;
  localparam int RXW = RX_SLOTS * 8;

  eng_state_e     state_q, state_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic           half_q, half_d;
  logic [RXW-1:0] rx_q, rx_d;
  logic [DW-1:0]  bit_ext;
  logic [BYW-1:0] byte_idx;
  logic [7:0]     cur_byte;
  logic           byte_hit;

  assign bit_ext  = DW'(bit_q);
  assign byte_idx = bit_q[BW-1:3];

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    half_d  = half_q;
    rx_d    = rx_q;
    case (state_q)
      ENG_IDLE: begin
        if (start_i) begin
          state_d = ENG_SHIFT;
          bit_d   = '0;
          half_d  = 1'b0;
          rx_d    = '0;
        end
      end
      ENG_SHIFT: begin
        if (half_end_i) begin
          if (!half_q) begin
            half_d = 1'b1;
            rx_d   = {rx_q[RXW-2:0], miso_i};
          end else begin
            half_d = 1'b0;
            if (bit_ext == len_i - DW'(1)) state_d = ENG_TAIL;
            else                           bit_d   = bit_q + BW'(1);
          end
        end
      end
      ENG_TAIL: begin
        if (half_end_i) state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      bit_q   <= '0;
      half_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      half_q  <= half_d;
      rx_q    <= rx_d;
    end
  end

  always_comb begin
    cur_byte = '0;
    byte_hit = 1'b0;
    for (int k = 0; k < TX_SLOTS; k++) begin
      if (byte_idx == BYW'(TX_SLOTS - 1 - k)) begin
        cur_byte = tx_i[k*8 +: 8];
        byte_hit = 1'b1;
      end
    end
  end

  assign busy_o = (state_q != ENG_IDLE);
  assign cs_n_o = (state_q == ENG_IDLE);
  assign sclk_o = half_q;
  assign mosi_o = (state_q == ENG_SHIFT) && byte_hit && cur_byte[~bit_q[2:0]];
  assign rx_o   = rx_q;

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o); // R3
  AST_NO_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_SHIFT) |=> (state_q != ENG_IDLE)); // R10
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_SHIFT) |-> (bit_ext < len_i)); // R3
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !mosi_o); // R1
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == ENG_IDLE)); // R2
endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter
  import spq_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter int TX_SLOTS = SPQ_TX_SLOTS,
  parameter int RX_SLOTS = SPQ_RX_SLOTS,
  parameter int MAX_BITS = SPQ_MAX_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sclk,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int HALF = DIV / 2;
  localparam int TXW  = TX_SLOTS * 8;
  localparam int RXW  = RX_SLOTS * 8;

  logic [1:0]     rst_sync_q;
  logic           rst_core_n;
  logic           busy_w, start_w, half_end_w;
  logic [TXW-1:0] tx_w;
  logic [RXW-1:0] rx_w;
  logic [DW-1:0]  len_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  spq_regs #(
    .AW(AW), .DW(DW), .TX_SLOTS(TX_SLOTS), .RX_SLOTS(RX_SLOTS), .MAX_BITS(MAX_BITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .busy_i(busy_w), .rx_i(rx_w), .rdata_o(reg_rdata),
    .tx_o(tx_w), .len_o(len_w), .start_o(start_w)
  );

  spq_half_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_core_n), .run_i(busy_w), .half_end_o(half_end_w)
  );

  spq_engine #(
    .DW(DW), .TX_SLOTS(TX_SLOTS), .RX_SLOTS(RX_SLOTS), .MAX_BITS(MAX_BITS)
  ) u_engine (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_w), .len_i(len_w),
    .tx_i(tx_w), .miso_i(miso), .half_end_i(half_end_w), .busy_o(busy_w),
    .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .rx_o(rx_w)
  );

  AST_BAD_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_wr && !busy_w && (reg_addr == AW'(SPQ_A_CMD)) && reg_wdata[SPQ_GO_BIT] &&
     ((len_w == '0) || (len_w > DW'(MAX_BITS)))) |=> cs_n); // R8
endmodule

// File: tb/spi_prog_shifter_tb_top.sv
module spi_prog_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_T      = 6;
  localparam int H          = DIV_T / 2;
  localparam logic [63:0] PAT = 64'hD3A5_1F08_6CE2_B749;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sclk, cs_n, mosi, miso;

  int n_chk = 0, n_fail = 0, cyc = 0, pat_idx = 0;
  bit chk_on = 0;
  bit prev_sclk = 0;

  logic [7:0] m_tx [6];
  logic [7:0] m_len;
  bit         m_busy;
  int         m_t, m_n;
  bit         rxq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_prog_shifter #(.DIV(DIV_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference model of the register file and engine state
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 6; k++) m_tx[k] = 8'h00;
      m_len = 8'h00; m_busy = 0; m_t = 0; m_n = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy) begin
        m_t++;
        if (m_t == 2*H*m_n + H) m_busy = 0;
      end
      if (reg_wr && !was_busy) begin
        if (reg_addr == 5'd0) begin
          if (reg_wdata[2] && m_len != 0 && m_len <= 56) begin
            m_busy = 1; m_t = 0; m_n = int'(m_len); rxq.delete();
          end
        end else if (reg_addr == 5'd1) m_len = reg_wdata;
        else if (reg_addr >= 5'd2 && reg_addr <= 5'd7) m_tx[reg_addr - 5'd2] = reg_wdata;
      end
    end
  end

  // per-cycle pin comparison and miso slave
  always @(negedge clk) begin
    if (chk_on) begin
      logic es, em;
      int b;
      es = 0; em = 0;
      if (m_busy && m_t < 2*H*m_n) begin
        b  = m_t / (2*H);
        es = (m_t % (2*H)) >= H;
        em = (b < 48) ? m_tx[5 - b/8][7 - b%8] : 1'b0;
        chk((b >= 48) ? "R5" : "R4", "mosi", 32'(mosi), 32'(em));
      end else begin
        chk("R1", "mosi idle", 32'(mosi), 32'(em));
      end
      chk("R7 R10", "cs_n", 32'(cs_n), 32'(!m_busy));
      chk("R3", "sclk", 32'(sclk), 32'(es));
    end
    if (sclk && !prev_sclk) begin
      rxq.push_back(miso);
      pat_idx++;
      miso = PAT[pat_idx % 64];
    end
    prev_sclk = sclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_rx(input string req);
    logic [79:0] v;
    logic [7:0]  d;
    v = '0;
    foreach (rxq[i]) v = {v[78:0], rxq[i]};
    for (int k = 0; k < 10; k++) begin
      rd(5'(8 + k), d);
      chk(req, $sformatf("rx slot %0d", k), 32'(d), 32'(v[k*8 +: 8]));
    end
  endtask

  task automatic load_tx(input logic [47:0] v);
    for (int k = 0; k < 6; k++) wr(5'(2 + k), v[k*8 +: 8]);
  endtask

  task automatic bad_len(input logic [7:0] l);
    logic [7:0] d;
    wr(5'd1, l);
    wr(5'd0, 8'h04);
    rd(5'd0, d);
    chk("R8", $sformatf("cmd after len %0d", l), 32'(d), 32'h0);
    repeat (4*H) @(negedge clk);
    chk("R8", "cs_n stays high", 32'(cs_n), 32'h1);
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; miso = PAT[0];
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk_on = 1;

    // R1 reset state
    chk("R1", "cs_n", 32'(cs_n), 32'h1);
    chk("R1", "sclk", 32'(sclk), 32'h0);
    rd(5'd0, d); chk("R1", "cmd", 32'(d), 32'h0);
    rd(5'd1, d); chk("R1", "len", 32'(d), 32'h0);

    // full 56-bit transfer with writes during busy (R2, R6, R7, R9)
    load_tx(48'h7E81_F00F_3CA5);
    wr(5'd1, 8'd56);
    wr(5'd0, 8'h04);
    chk("R2", "cs_n low after go", 32'(cs_n), 32'h0);
    rd(5'd0, d); chk("R2", "cmd busy", 32'(d), 32'h04);
    wr(5'd7, 8'h00);
    wr(5'd1, 8'd9);
    wr(5'd0, 8'h04);
    wait_idle();
    rd(5'd0, d); chk("R7", "cmd cleared", 32'(d), 32'h0);
    rd(5'd7, d); chk("R9", "tx5 kept", 32'(d), 32'h7E);
    rd(5'd1, d); chk("R9", "len kept", 32'(d), 32'd56);
    check_rx("R6");

    // partial byte length (R4, R6)
    load_tx(48'h1122_3344_C5B6);
    wr(5'd1, 8'd12);
    wr(5'd0, 8'h04);
    wait_idle();
    check_rx("R6");

    // single bit (R3)
    wr(5'd1, 8'd1);
    wr(5'd0, 8'h04);
    wait_idle();
    check_rx("R6");

    // beyond loaded bytes (R5)
    load_tx(48'hFFFF_FFFF_FFFF);
    wr(5'd1, 8'd50);
    wr(5'd0, 8'h04);
    wait_idle();
    check_rx("R6");

    // rejected lengths (R8)
    bad_len(8'd0);
    bad_len(8'd57);
    bad_len(8'd255);

    repeat (4) @(negedge clk);
    report();
  end
endmodule